// File: doc/BRIEF.md
# Weighted Round-Robin Stream Arbiter

This block lets four accelerator slots share one host-bound stream. Each slot offers packets on its own AXI4-Stream source port, 256 data bits wide. The arbiter grants one slot at a time and passes that slot's beats to a single AXI4-Stream output. It returns the output's ready only to the granted slot. A grant is never withdrawn in the middle of a packet.

Slots that are not requesting are skipped, so the bandwidth is split only among the slots that are active. Each slot also has a 4-bit weight input. A slot with weight W may send up to W packets in a row before the turn passes on; a weight of 0 counts as one packet. Equal weights therefore give equal shares, and a larger weight gives a slot more of the stream.

A turn ends when the slot has used up its packets, or when the slot has nothing valid at a packet boundary. The next search then starts at the slot after the one that just finished. Taking a new grant costs one idle output cycle.

Top module: `wrr_stream_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `m_tvalid` and all bits of `s_tready` are low. The rotation pointer starts at slot 0, so the first grant after reset goes to the lowest-numbered slot that is requesting.
- R2: While a slot holds the grant, the output carries that slot's signals: `m_tvalid` equals the slot's valid, and `m_tdata` and `m_tlast` equal its data and last flag. Slot k's data sits at bits [k*256 +: 256] of `s_tdata`.
- R3: At most one bit of `s_tready` is high at any time. That bit is the granted slot's, and it equals `m_tready`. With no grant, all bits are low.
- R4: Once a beat without TLAST has been accepted at the output, every further output beat comes from the same slot until a beat with TLAST is accepted.
- R5: When a turn ends, the search for the next grant starts at the slot after the one that finished, wrapping from slot 3 to slot 0. The first requesting slot found in that order wins.
- R6: A slot whose `s_tvalid` is low when the grant is decided is passed over. With only some slots active, the turns alternate among those slots alone.
- R7: Slot k's weight is bits [k*4 +: 4] of `slot_weight`. A granted slot sends up to W packets in one turn, or one packet when W is 0, before the turn passes on.
- R8: If the granted slot has `s_tvalid` low at a packet boundary before it has used its packets, its turn ends at once.
- R9: While no slot is requesting and none holds the grant, `m_tvalid` stays low and the rotation pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_weight | input | 16 | Packets per turn for each slot, 4 bits per slot |
| s_tvalid | input | 4 | Valid from each slot |
| s_tready | output | 4 | Ready to each slot |
| s_tdata | input | 1024 | Data from each slot, 256 bits per slot |
| s_tlast | input | 4 | Last-beat flag from each slot |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |
| m_tdata | output | 256 | Output data |
| m_tlast | output | 1 | Output last-beat flag |

## Verification
Two events can fall in the same cycle: the accepted last beat that uses up the granted slot's weight, and a new request from another slot that the following search has to weigh against the rotation pointer. Directed runs with every slot saturated provoke this case on each turn. Further runs use idle slots, single-packet slots and a pointer left over from an idle stretch. Random runs with valid gaps and output back-pressure place the two events at arbitrary offsets. The order in which packets leave is compared with an order the bench derives from the weights and counts. Every accepted beat is matched against the data its slot sent, and packets must stay unbroken.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;

  // Packets allowed in one turn: a zero weight still grants one packet.
  function automatic int unsigned eff_weight(input int unsigned w);
    return (w == 0) ? 1 : w;
  endfunction

  // Next slot in rotation order, wrapping at n.
  function automatic int unsigned wrap_inc(input int unsigned i, input int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

  // Slot reached after stepping 'step' places from 'base'.
  function automatic int unsigned wrap_add(input int unsigned base, input int unsigned step,
                                           input int unsigned n);
    int unsigned s;
    s = base + step;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/wrr_pick.sv
module wrr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] start,
  output logic             any_req,
  output logic [IDX_W-1:0] win
);
  import wrr_arb_pkg::*;

  // Rotating priority: the first requester at or after 'start' wins.
  always_comb begin
    logic found;
    int unsigned cand;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < N; i++) begin
      cand = wrap_add(int'(start), i, N);
      if (!found && req[cand]) begin
        found = 1'b1;
        win   = IDX_W'(cand);
      end
    end
  end

  assign any_req = |req;

endmodule

// File: rtl/wrr_out_mux.sv
module wrr_out_mux #(
  parameter int N      = 4,
  parameter int DATA_W = 256,
  parameter int IDX_W  = 2
) (
  input  logic                busy,
  input  logic [IDX_W-1:0]    gnt,
  input  logic [N-1:0]        s_tvalid,
  input  logic [N*DATA_W-1:0] s_tdata,
  input  logic [N-1:0]        s_tlast,
  input  logic                m_tready,
  output logic [N-1:0]        s_tready,
  output logic                m_tvalid,
  output logic [DATA_W-1:0]   m_tdata,
  output logic                m_tlast,
  output logic                beat_acc,
  output logic                pkt_end
);

  assign m_tvalid = busy & s_tvalid[gnt];
  assign m_tdata  = s_tdata[gnt*DATA_W +: DATA_W];
  assign m_tlast  = s_tlast[gnt];

  // Ready goes back only to the slot that holds the grant.
  for (genvar g = 0; g < N; g++) begin : g_rdy
    assign s_tready[g] = busy && (gnt == IDX_W'(g)) && m_tready;
  end

  assign beat_acc = m_tvalid & m_tready;
  assign pkt_end  = beat_acc & m_tlast;

endmodule

// File: rtl/wrr_turn_ctrl.sv
module wrr_turn_ctrl #(
  parameter int N     = 4,
  parameter int WT_W  = 4,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      s_tvalid,
  input  logic [N*WT_W-1:0] slot_weight,
  input  logic              pick_any,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic              beat_acc,
  input  logic              pkt_end,
  output logic              busy,
  output logic [IDX_W-1:0]  gnt,
  output logic [IDX_W-1:0]  ptr,
  output logic              turn_end
);
  import wrr_arb_pkg::*;

  logic [WT_W-1:0] cred;
  logic            mid;
  logic [WT_W-1:0] load_cred;
  logic            last_credit;
  logic            went_quiet;
  logic [IDX_W-1:0] after_gnt;

  assign load_cred   = WT_W'(eff_weight(int'(slot_weight[pick_idx*WT_W +: WT_W])));
  assign last_credit = (cred == WT_W'(1));
  assign went_quiet  = !mid && !s_tvalid[gnt];
  assign turn_end    = busy && ((pkt_end && last_credit) || (!beat_acc && went_quiet));
  assign after_gnt   = IDX_W'(wrap_inc(int'(gnt), N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      gnt  <= '0;
      ptr  <= '0;
      cred <= '0;
      mid  <= 1'b0;
    end else if (!busy) begin
      if (pick_any) begin
        busy <= 1'b1;
        gnt  <= pick_idx;
        cred <= load_cred;
        mid  <= 1'b0;
      end
    end else if (turn_end) begin
      busy <= 1'b0;
      mid  <= 1'b0;
      ptr  <= after_gnt;
    end else if (pkt_end) begin
      mid  <= 1'b0;
      cred <= cred - WT_W'(1);
    end else if (beat_acc) begin
      mid  <= 1'b1;
    end
  end

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && s_tvalid == '0) |=> $stable(ptr));

  // R6
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(s_tvalid) != '0));

  // R7
  cred_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cred != '0));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_end |=> (!busy && ptr == IDX_W'(wrap_inc(int'($past(gnt)), N))));

endmodule

// File: rtl/wrr_stream_arb.sv
module wrr_stream_arb #(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 256,
  parameter int WT_W      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS*WT_W-1:0]   slot_weight,
  input  logic [NUM_SLOTS-1:0]        s_tvalid,
  output logic [NUM_SLOTS-1:0]        s_tready,
  input  logic [NUM_SLOTS*DATA_W-1:0] s_tdata,
  input  logic [NUM_SLOTS-1:0]        s_tlast,
  output logic                        m_tvalid,
  input  logic                        m_tready,
  output logic [DATA_W-1:0]           m_tdata,
  output logic                        m_tlast
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             busy;
  logic [IDX_W-1:0] gnt;
  logic [IDX_W-1:0] ptr;
  logic             turn_end;
  logic             beat_acc;
  logic             pkt_end;

  wrr_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .req     (s_tvalid),
    .start   (ptr),
    .any_req (pick_any),
    .win     (pick_idx)
  );

  wrr_turn_ctrl #(.N(NUM_SLOTS), .WT_W(WT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_tvalid    (s_tvalid),
    .slot_weight (slot_weight),
    .pick_any    (pick_any),
    .pick_idx    (pick_idx),
    .beat_acc    (beat_acc),
    .pkt_end     (pkt_end),
    .busy        (busy),
    .gnt         (gnt),
    .ptr         (ptr),
    .turn_end    (turn_end)
  );

  wrr_out_mux #(.N(NUM_SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
    .busy     (busy),
    .gnt      (gnt),
    .s_tvalid (s_tvalid),
    .s_tdata  (s_tdata),
    .s_tlast  (s_tlast),
    .m_tready (m_tready),
    .s_tready (s_tready),
    .m_tvalid (m_tvalid),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .beat_acc (beat_acc),
    .pkt_end  (pkt_end)
  );

  // R4
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc && !m_tlast) |=> (busy && gnt == $past(gnt)));

  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (s_tready == '0));

  // R3
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s_tready) <= 1);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!m_tvalid && s_tready == '0));

endmodule

// File: tb/sim_wrr_stream_arb.sv
module sim_wrr_stream_arb;
  localparam int N  = 4;
  localparam int DW = 256;
  localparam int WW = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N*WW-1:0] slot_weight;
  logic [N-1:0]    s_tvalid, s_tready, s_tlast;
  logic [N*DW-1:0] s_tdata;
  logic            m_tvalid, m_tready, m_tlast;
  logic [DW-1:0]   m_tdata;

  always #5 clk = ~clk;

  wrr_stream_arb u0 (
    .clk(clk), .rst_n(rst_n), .slot_weight(slot_weight),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  int vectors = 0, miscompares = 0;
  int pkt_left[N], pkt_sent[N], beat_no[N], loaded[N], got[N];
  bit vld[N];
  int tw[N], tc[N];
  bit open_pkt;
  int open_slot;
  int src_log[$];
  int exp_q[$];
  int model_ptr;
  int gap_pct, rdy_pct;
  bit drive_on;

  function automatic int plen(int s, int p);
    return 1 + ((s * 3 + p * 5) % 4);
  endfunction

  function automatic int effw(int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic logic [DW-1:0] mk(int s, int p, int b);
    logic [DW-1:0] d;
    d = {8{32'h5A3C_9E61 ^ 32'(s * 32'h0101_0101 + p)}};
    d[7:0]   = 8'(s);
    d[23:8]  = 16'(p);
    d[39:24] = 16'(b);
    return d;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Turn-level order derived from weights, counts and the rotation pointer.
  task automatic model_order();
    int rem[N];
    int s, take;
    bit more;
    exp_q.delete();
    for (int k = 0; k < N; k++) rem[k] = tc[k];
    more = 1'b1;
    while (more) begin
      s = -1;
      for (int i = 0; i < N; i++) begin
        int c;
        c = (model_ptr + i) % N;
        if (s < 0 && rem[c] > 0) s = c;
      end
      if (s < 0) more = 1'b0;
      else begin
        take = (effw(tw[s]) < rem[s]) ? effw(tw[s]) : rem[s];
        for (int j = 0; j < take; j++) exp_q.push_back(s);
        rem[s] -= take;
        model_ptr = (s + 1) % N;
      end
    end
  endtask

  // Stimulus and checking engine: drive at the falling edge, look 1 ns later.
  initial begin
    forever begin
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
        if (!drive_on) vld[k] = 1'b0;
        else if (!vld[k] && pkt_left[k] > 0 && $urandom_range(99) >= gap_pct) vld[k] = 1'b1;
        s_tvalid[k] = vld[k];
        s_tdata[k*DW +: DW] = mk(k, pkt_sent[k], beat_no[k]);
        s_tlast[k] = (beat_no[k] == plen(k, pkt_sent[k]) - 1);
        slot_weight[k*WW +: WW] = WW'(tw[k]);
      end
      m_tready = drive_on && ($urandom_range(99) < rdy_pct);
      #1;
      if (rst_n && drive_on) begin
        bit took;
        took = 1'b0;
        chk($countones(s_tready) <= 1, "R3", "ready bits high", $countones(s_tready), 1);
        if (!m_tready) chk(s_tready == '0, "R3", "ready with output stalled", s_tready, 0);
        for (int k = 0; k < N; k++) begin
          if (s_tvalid[k] && s_tready[k]) begin
            took = 1'b1;
            chk(m_tvalid == 1'b1, "R2", "output valid on slot beat", m_tvalid, 1);
            chk(m_tdata == mk(k, pkt_sent[k], beat_no[k]), "R2", "output data",
                m_tdata[39:0], mk(k, pkt_sent[k], beat_no[k]) & 40'hFF_FFFF_FFFF);
            chk(m_tlast == s_tlast[k], "R2", "output last", m_tlast, s_tlast[k]);
            if (open_pkt) chk(k == open_slot, "R4", "beat source mid-packet", k, open_slot);
            open_pkt  = !s_tlast[k];
            open_slot = k;
            if (s_tlast[k]) begin
              src_log.push_back(k);
              got[k]++;
              beat_no[k] = 0;
              pkt_sent[k]++;
              pkt_left[k]--;
            end else beat_no[k]++;
            vld[k] = 1'b0;
          end
        end
        if (m_tvalid && m_tready && !took) chk(1'b0, "R3", "output beat with no slot ready", 1, 0);
      end
    end
  end

  task automatic do_reset();
    drive_on = 1'b0;
    rst_n = 1'b0;
    for (int k = 0; k < N; k++) begin
      pkt_left[k] = 0; pkt_sent[k] = 0; beat_no[k] = 0; loaded[k] = 0; got[k] = 0;
      vld[k] = 1'b0; tw[k] = 0; tc[k] = 0;
    end
    open_pkt = 1'b0;
    src_log.delete();
    model_ptr = 0;
    repeat (3) @(posedge clk);
    #2;
    chk(m_tvalid == 1'b0, "R1", "valid in reset", m_tvalid, 0);
    chk(s_tready == '0, "R1", "ready in reset", s_tready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk(m_tvalid == 1'b0, "R1", "valid after reset", m_tvalid, 0);
    chk(s_tready == '0, "R1", "ready after reset", s_tready, 0);
  endtask

  task automatic start_load(int g, int r);
    @(posedge clk);
    #1;
    gap_pct = g;
    rdy_pct = r;
    src_log.delete();
    for (int k = 0; k < N; k++) begin
      pkt_left[k] = tc[k]; pkt_sent[k] = 0; beat_no[k] = 0; loaded[k] = tc[k]; got[k] = 0;
    end
    drive_on = 1'b1;
  endtask

  task automatic wait_done(string req);
    int cyc;
    bit busy_left;
    cyc = 0;
    busy_left = 1'b1;
    while (busy_left && cyc < 20000) begin
      @(posedge clk);
      cyc++;
      busy_left = open_pkt;
      for (int k = 0; k < N; k++) if (pkt_left[k] > 0) busy_left = 1'b1;
    end
    chk(!busy_left, req, "all packets delivered", busy_left, 0);
    #1;
    drive_on = 1'b0;
  endtask

  task automatic cmp_order(string req);
    chk(src_log.size() == exp_q.size(), req, "packet count", src_log.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < src_log.size(); i++)
      chk(src_log[i] == exp_q[i], req, $sformatf("source of packet %0d", i), src_log[i], exp_q[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 watchdog: actual run unfinished expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    s_tvalid = '0; s_tlast = '0; s_tdata = '0; slot_weight = '0; m_tready = 1'b0;
    gap_pct = 0; rdy_pct = 100;
    do_reset();

    // R1 R5 R7: all slots saturated with weights 0,2,1,3; pointer starts at slot 0.
    tw = '{0, 2, 1, 3}; tc = '{10, 10, 10, 10};
    model_order();
    start_load(0, 100);
    wait_done("R7");
    cmp_order("R7");

    // R6: only slots 1 and 3 request.
    do_reset();
    tw = '{0, 0, 0, 0}; tc = '{0, 3, 0, 3};
    model_order();
    start_load(0, 100);
    wait_done("R6");
    cmp_order("R6");

    // R8: slot 2 has weight 3 but a single packet, so its turn ends early.
    tw = '{0, 0, 3, 0}; tc = '{2, 0, 1, 0};
    model_order();
    start_load(0, 100);
    wait_done("R8");
    cmp_order("R8");

    // R9: idle stretch keeps the output quiet and the pointer in place.
    for (int i = 0; i < 12; i++) begin
      @(posedge clk);
      #2;
      chk(m_tvalid == 1'b0, "R9", "valid while idle", m_tvalid, 0);
    end
    tw = '{0, 0, 0, 0}; tc = '{1, 0, 0, 1};
    model_order();
    start_load(0, 100);
    wait_done("R9");
    cmp_order("R5");

    // R2 R3 R4: random gaps, back-pressure and weights.
    for (int run = 0; run < 3; run++) begin
      do_reset();
      for (int k = 0; k < N; k++) begin
        tw[k] = $urandom_range(15);
        tc[k] = $urandom_range(12, 3);
      end
      start_load(run == 0 ? 30 : 60, run == 2 ? 35 : 70);
      wait_done("R2");
      for (int k = 0; k < N; k++)
        chk(got[k] == loaded[k], "R2", $sformatf("packets from slot %0d", k), got[k], loaded[k]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule